// File: doc/BRIEF.md
# Priority NMI Controller with One-Shot Service

This block gathers interrupt requests from eight sources and signals them to a processor on a single active-low non-maskable interrupt line. A rising edge on a source line sets that source's pending bit. When the controller is enabled, it is idle and no return is outstanding, it selects the pending source with the highest index. In that same cycle it latches the source's index as the vector and pulls `nmi_n` low. The vector and the line then stay fixed until the processor acknowledges. The acknowledge releases the line and retires the pending bit of the latched source.

Software drives the block through one five-bit control write. The command bits are active low, so writing all ones gives normal operation. Three bits act for one cycle only: a soft reset, a flush of all pending requests, and a one-shot command that enables the controller. The other two bits are held as state: the enable, and an auto-off arm that disables the controller again at the moment an interrupt is signalled. Together, the arm and the one-shot command let a main loop take exactly one interrupt whenever it has time for one. A separate return-notice strobe, written just before the return from a service routine, blocks any new signalling until the processor reports that the return has finished.

Top module: `pic_nmi_ctrl`

## Requirements
- R1: After hardware reset, `nmi_n` is 1, `en_o` is 0 (disabled), `arm_n_o` is 1 (auto-off not armed) and no request is pending.
- R2: A source sampled high on one edge and low on the edge before sets its pending bit at that edge. The pending bit is set even while the controller is disabled. A line held high is captured only once.
- R3: When enabled, idle and not held, the controller latches the highest-index pending source into `vec_o` and drives `nmi_n` low at the clock edge after the pending bit was set.
- R4: `ack` while `nmi_n` is low raises `nmi_n` at the next edge and clears the pending bit of the source in `vec_o`. Other pending sources are then signalled in turn.
- R5: While `nmi_n` is low, a new higher-index request, a disable write or a flush write leaves `nmi_n` low and `vec_o` unchanged.
- R6: Control write bit 2 is the enable: 0 disables and 1 enables, and `en_o` reads it back. While the controller is disabled, `nmi_n` never falls.
- R7: Control write bit 1 = 0 clears every pending bit at that edge, and no interrupt is signalled at that edge. A later enable then signals nothing.
- R8: Control write bit 0 = 0 is a soft reset that restores the R1 state, releases `nmi_n` and ignores the other bits of that write. The soft reset also forgets the previous source levels, so a line still high afterwards is captured again.
- R9: Control write bit 3 = 0 arms auto-off and 1 cancels it, and `arm_n_o` reads it back. While auto-off is armed, the enable clears at the edge where `nmi_n` falls.
- R10: Control write bit 4 = 0 enables the controller whatever bit 2 holds. Combined with bit 3 = 0, exactly one interrupt (the highest-index pending one) is served, and the others stay pending until the next enable.
- R11: A pulse on `ret_we` prevents `nmi_n` from falling, from that edge onward, until the edge after the one at which `ret_done` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 8 | Request lines, edge-captured, index 7 highest |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 5 | Control word: bit4 one-shot_n, bit3 arm_n, bit2 enable, bit1 flush_n, bit0 soft-reset_n |
| ret_we | input | 1 | Return-notice write strobe |
| ret_done | input | 1 | Processor reports that the return has completed |
| ack | input | 1 | Processor acknowledges the signalled interrupt |
| nmi_n | output | 1 | Active-low interrupt line |
| vec_o | output | 3 | Index of the latched source |
| en_o | output | 1 | Enable readback, 1 = enabled |
| arm_n_o | output | 1 | Auto-off readback, 0 = armed |

## Verification
The bench drives commands that arrive while the line is already low: disable, flush and a higher-priority request. A design that re-arbitrated or cancelled would move `vec_o` or raise `nmi_n`. It checks a flush that lands on the very edge where an interrupt would fire, which exposes a design that signals a request it has just discarded. It runs one-shot service with auto-off armed, so a controller that stayed enabled would go on to serve the second pending source. It times the release after `ret_done` to the exact edge, and after a soft reset it checks that a line still held high is captured again.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int unsigned SRC_N = 8;

    // Control write word; bit 4 down to bit 0.
    typedef struct packed {
        logic once_n;   // 0: enable now (one-shot service)
        logic arm_n;    // 0: arm auto-off, 1: cancel it
        logic en;       // 1: enable, 0: disable
        logic flush_n;  // 0: drop all pending requests
        logic rst_n;    // 0: soft reset
    } ctl_word_t;

    localparam int unsigned CTL_W = $bits(ctl_word_t);

endpackage

// File: rtl/pic_capture.sv
module pic_capture #(
    parameter int unsigned NSRC = pic_pkg::SRC_N
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            soft_clr,
    input  logic            flush,
    input  logic [NSRC-1:0] irq,
    input  logic [NSRC-1:0] ack_clr,
    output logic [NSRC-1:0] pend
);

    logic [NSRC-1:0] irq_q;
    logic [NSRC-1:0] rise;

    assign rise = irq & ~irq_q;

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            irq_q <= '0;
            pend  <= '0;
        end else begin
            irq_q <= irq;
            if (flush) pend <= '0;
            else       pend <= (pend & ~ack_clr) | rise;
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        a_r2_edge_latched: assert property (@(posedge clk) disable iff (rst)
            (!soft_clr && !flush && rise[i]) |=> pend[i]);
        a_r7_flush_empties: assert property (@(posedge clk) disable iff (rst)
            (flush && !soft_clr) |=> !pend[i]);
    end

endmodule

// File: rtl/pic_pick.sv
module pic_pick #(
    parameter int unsigned NSRC = pic_pkg::SRC_N,
    localparam int unsigned VW  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] pend,
    output logic            any,
    output logic [VW-1:0]   idx
);

    always_comb begin
        any = |pend;
        idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend[i]) idx = VW'(i);
        end
    end

    // R3: chosen bit is set and nothing above it is.
    always_comb begin
        if (any) begin
            a_r3_highest_pick: assert ((pend >> idx) == {{(NSRC-1){1'b0}}, 1'b1});
        end
    end

endmodule

// File: rtl/pic_ctl.sv
module pic_ctl #(
    parameter int unsigned NSRC = pic_pkg::SRC_N,
    localparam int unsigned VW  = $clog2(NSRC)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ctl_we,
    input  pic_pkg::ctl_word_t  ctl_w,
    input  logic                ret_we,
    input  logic                ret_done,
    input  logic                ack,
    input  logic                any,
    input  logic [VW-1:0]       pick_idx,
    output logic                soft_clr,
    output logic                flush,
    output logic [NSRC-1:0]     ack_clr,
    output logic                nmi_n,
    output logic [VW-1:0]       vec,
    output logic                en,
    output logic                arm_n
);

    logic nmi_n_q, en_q, arm_n_q, hold_q;
    logic [VW-1:0] vec_q;
    logic fire, take_ack;

    assign soft_clr = ctl_we && !ctl_w.rst_n;
    assign flush    = ctl_we && ctl_w.rst_n && !ctl_w.flush_n;
    assign take_ack = !nmi_n_q && ack;
    assign fire     = nmi_n_q && en_q && !hold_q && any
                      && !soft_clr && !flush && !ret_we;

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            ack_clr[i] = take_ack && (vec_q == VW'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            nmi_n_q <= 1'b1;
            en_q    <= 1'b0;
            arm_n_q <= 1'b1;
            hold_q  <= 1'b0;
            vec_q   <= '0;
        end else begin
            if (fire) begin
                nmi_n_q <= 1'b0;
                vec_q   <= pick_idx;
            end else if (take_ack) begin
                nmi_n_q <= 1'b1;
            end
            if (fire && !arm_n_q)  en_q <= 1'b0;
            else if (ctl_we)       en_q <= ctl_w.en || !ctl_w.once_n;
            if (ctl_we)            arm_n_q <= ctl_w.arm_n;
            if (ret_we)            hold_q <= 1'b1;
            else if (ret_done)     hold_q <= 1'b0;
        end
    end

    assign nmi_n = nmi_n_q;
    assign vec   = vec_q;
    assign en    = en_q;
    assign arm_n = arm_n_q;

    a_r6_fall_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $fell(nmi_n_q) |-> $past(en_q));
    a_r11_no_fall_in_hold: assert property (@(posedge clk) disable iff (rst)
        $fell(nmi_n_q) |-> !$past(hold_q));
    a_r5_vec_frozen: assert property (@(posedge clk) disable iff (rst)
        (!nmi_n_q && !$past(nmi_n_q)) |-> $stable(vec_q));
    a_r9_auto_off: assert property (@(posedge clk) disable iff (rst)
        ($fell(nmi_n_q) && !$past(arm_n_q)) |-> !en_q);
    a_r4_ack_release: assert property (@(posedge clk) disable iff (rst)
        (!nmi_n_q && ack) |=> nmi_n_q);

endmodule

// File: rtl/pic_nmi_ctrl.sv
module pic_nmi_ctrl #(
    parameter int unsigned NSRC = pic_pkg::SRC_N,
    localparam int unsigned VW  = $clog2(NSRC),
    localparam int unsigned CW  = pic_pkg::CTL_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] irq_i,
    input  logic            ctl_we,
    input  logic [CW-1:0]   ctl_wdata,
    input  logic            ret_we,
    input  logic            ret_done,
    input  logic            ack,
    output logic            nmi_n,
    output logic [VW-1:0]   vec_o,
    output logic            en_o,
    output logic            arm_n_o
);

    pic_pkg::ctl_word_t ctl_w;
    logic              soft_clr, flush, any;
    logic [NSRC-1:0]   pend, ack_clr;
    logic [VW-1:0]     pick_idx;

    assign ctl_w = pic_pkg::ctl_word_t'(ctl_wdata);

    pic_capture #(.NSRC(NSRC)) u_cap (
        .clk(clk), .rst(rst), .soft_clr(soft_clr), .flush(flush),
        .irq(irq_i), .ack_clr(ack_clr), .pend(pend)
    );

    pic_pick #(.NSRC(NSRC)) u_pick (
        .pend(pend), .any(any), .idx(pick_idx)
    );

    pic_ctl #(.NSRC(NSRC)) u_ctl (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_w(ctl_w),
        .ret_we(ret_we), .ret_done(ret_done), .ack(ack),
        .any(any), .pick_idx(pick_idx),
        .soft_clr(soft_clr), .flush(flush), .ack_clr(ack_clr),
        .nmi_n(nmi_n), .vec(vec_o), .en(en_o), .arm_n(arm_n_o)
    );

    // R4: the acknowledged source leaves pending.
    a_r4_ack_retires: assert property (@(posedge clk) disable iff (rst)
        (!nmi_n && ack && !soft_clr && !flush) |=> !pend[$past(vec_o)] || $past(irq_i[vec_o]));

endmodule

// File: tb/tb_pic_nmi_ctrl.sv
module tb_pic_nmi_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq = '0;
    logic       ctl_we = 1'b0;
    logic [4:0] ctl_wdata = 5'b11111;
    logic       ret_we = 1'b0;
    logic       ret_done = 1'b0;
    logic       ack = 1'b0;
    logic       nmi_n;
    logic [2:0] vec_o;
    logic       en_o;
    logic       arm_n_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pic_nmi_ctrl dut (
        .clk(clk), .rst(rst), .irq_i(irq), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ret_we(ret_we), .ret_done(ret_done), .ack(ack),
        .nmi_n(nmi_n), .vec_o(vec_o), .en_o(en_o), .arm_n_o(arm_n_o)
    );

    // {pattern, expected first vector}
    localparam logic [10:0] VECS [6] = '{
        {8'h01, 3'd0}, {8'h80, 3'd7}, {8'h0A, 3'd3},
        {8'hFF, 3'd7}, {8'h30, 3'd5}, {8'h44, 3'd6}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(logic [4:0] d);
        ctl_we = 1'b1; ctl_wdata = d;
        tick();
        ctl_we = 1'b0; ctl_wdata = 5'b11111;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        tick();
        ack = 1'b0;
    endtask

    initial begin
        repeat (4) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 nmi_n", {7'd0, nmi_n}, 8'd1);
        chk("R1 en_o", {7'd0, en_o}, 8'd0);
        chk("R1 arm_n_o", {7'd0, arm_n_o}, 8'd1);

        // R6 disabled: edge captured but not signalled
        irq = 8'h04; tick(); irq = 8'h00;
        tick(); tick(); tick();
        chk("R6 disabled no nmi", {7'd0, nmi_n}, 8'd1);
        wr(5'b11111);
        chk("R6 en_o readback", {7'd0, en_o}, 8'd1);
        chk("R6 nmi not yet", {7'd0, nmi_n}, 8'd1);
        tick();
        chk("R2 captured while disabled", {7'd0, nmi_n}, 8'd0);
        chk("R3 vec", {5'd0, vec_o}, 8'd2);
        do_ack();
        chk("R4 release", {7'd0, nmi_n}, 8'd1);

        // R3/R4 vector table
        foreach (VECS[k]) begin
            irq = VECS[k][10:3];
            tick(); tick();
            chk("R3 nmi low", {7'd0, nmi_n}, 8'd0);
            chk("R3 table vec", {5'd0, vec_o}, {5'd0, VECS[k][2:0]});
            do_ack();
            chk("R4 ack release", {7'd0, nmi_n}, 8'd1);
            irq = 8'h00;
            wr(5'b11101);
            tick();
            chk("R7 flushed no nmi", {7'd0, nmi_n}, 8'd1);
        end

        // R4 remaining pending served in turn
        irq = 8'h12; tick(); irq = 8'h00; tick();
        chk("R4 first", {5'd0, vec_o}, 8'd4);
        do_ack(); tick();
        chk("R4 second nmi", {7'd0, nmi_n}, 8'd0);
        chk("R4 second vec", {5'd0, vec_o}, 8'd1);
        do_ack();

        // R2 level held captured once
        irq = 8'h02; tick(); tick();
        chk("R2 nmi", {7'd0, nmi_n}, 8'd0);
        do_ack();
        tick(); tick(); tick();
        chk("R2 held level once", {7'd0, nmi_n}, 8'd1);

        // R5 in-flight not cancelled
        irq = 8'h00; tick();
        irq = 8'h02; tick(); tick();
        chk("R5 nmi", {7'd0, nmi_n}, 8'd0);
        irq = 8'h42; tick(); tick();
        chk("R5 higher req vec", {5'd0, vec_o}, 8'd1);
        wr(5'b11011);
        chk("R5 disable keeps nmi", {7'd0, nmi_n}, 8'd0);
        wr(5'b11001);
        chk("R5 flush keeps nmi", {7'd0, nmi_n}, 8'd0);
        chk("R5 flush keeps vec", {5'd0, vec_o}, 8'd1);
        do_ack();
        tick(); tick();
        chk("R6 disabled stays high", {7'd0, nmi_n}, 8'd1);
        wr(5'b11111); tick(); tick();
        chk("R7 flushed req gone", {7'd0, nmi_n}, 8'd1);
        irq = 8'h00; tick();

        // R7 flush on the firing edge
        irq = 8'h10; tick();
        wr(5'b11101);
        chk("R7 flush gates fire", {7'd0, nmi_n}, 8'd1);
        tick();
        chk("R7 no later fire", {7'd0, nmi_n}, 8'd1);
        irq = 8'h00; tick();

        // R8 soft reset
        irq = 8'h28; tick(); tick();
        chk("R8 pre vec", {5'd0, vec_o}, 8'd5);
        irq = 8'h20;
        wr(5'b11110);
        chk("R8 nmi released", {7'd0, nmi_n}, 8'd1);
        chk("R8 en cleared", {7'd0, en_o}, 8'd0);
        chk("R8 arm off", {7'd0, arm_n_o}, 8'd1);
        wr(5'b11111);
        tick();
        chk("R8 recapture nmi", {7'd0, nmi_n}, 8'd0);
        chk("R8 recapture vec", {5'd0, vec_o}, 8'd5);
        do_ack();
        irq = 8'h00; tick(); tick();
        chk("R8 other pending cleared", {7'd0, nmi_n}, 8'd1);

        // R9 auto-off
        wr(5'b10111);
        chk("R9 arm readback", {7'd0, arm_n_o}, 8'd0);
        irq = 8'h01; tick(); irq = 8'h00; tick();
        chk("R9 nmi", {7'd0, nmi_n}, 8'd0);
        chk("R9 en auto cleared", {7'd0, en_o}, 8'd0);
        do_ack();
        irq = 8'h08; tick(); irq = 8'h00; tick(); tick();
        chk("R9 no second nmi", {7'd0, nmi_n}, 8'd1);
        wr(5'b11101); tick();

        // R10 one-shot
        wr(5'b11011);
        irq = 8'h06; tick(); irq = 8'h00; tick();
        wr(5'b00011);
        chk("R10 enabled by one-shot", {7'd0, en_o}, 8'd1);
        chk("R10 armed", {7'd0, arm_n_o}, 8'd0);
        tick();
        chk("R10 nmi", {7'd0, nmi_n}, 8'd0);
        chk("R10 vec", {5'd0, vec_o}, 8'd2);
        chk("R10 en off", {7'd0, en_o}, 8'd0);
        do_ack();
        tick(); tick(); tick();
        chk("R10 only one served", {7'd0, nmi_n}, 8'd1);
        wr(5'b11111);
        chk("R9 arm cancelled", {7'd0, arm_n_o}, 8'd1);
        tick();
        chk("R10 rest pending vec", {5'd0, vec_o}, 8'd1);
        chk("R10 rest pending nmi", {7'd0, nmi_n}, 8'd0);
        do_ack();

        // R11 return hold
        ret_we = 1'b1; tick();
        ret_we = 1'b0; irq = 8'h10; tick();
        irq = 8'h00;
        tick(); tick(); tick();
        chk("R11 held", {7'd0, nmi_n}, 8'd1);
        ret_done = 1'b1; tick(); ret_done = 1'b0;
        chk("R11 not yet", {7'd0, nmi_n}, 8'd1);
        tick();
        chk("R11 released nmi", {7'd0, nmi_n}, 8'd0);
        chk("R11 released vec", {5'd0, vec_o}, 8'd4);
        do_ack();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule